// File: doc/BRIEF.md
# Dithered Frame PWM Generator

This block drives one pulse-width-modulated output pin. Time is cut into frames of 32 PWM ticks. Eight consecutive frames form a group, and the group is the full output period. A 5-bit coarse duty sets how many ticks are high at the start of every frame. A 3-bit fine duty picks how many of the eight frames in a group carry one extra high tick. Together the two fields act as an 8-bit duty word, so the average duty moves in steps of 1/256 while each frame stays only 32 ticks long. The frame rate stays high, which keeps the ripple easy to filter.

The PWM tick is derived from the system clock by a power-of-two divider, with a 2-bit select choosing 2, 4, 8 or 16 clocks per tick. The duty fields are sampled only at a group boundary. A write made part-way through a group therefore never produces a mixed period.

Top module: `frac_pwm`

## Requirements
- R1: Reset is synchronous and active low. Any clock edge that samples `rst_n` low clears all counters and the stored duty, and `pwm_out` is 0 after that edge. The whole first group after reset is low whatever the duty inputs hold.
- R2: One PWM tick lasts 2^(`cfg_div_sel`+1) system clocks: 2, 4, 8 or 16 clocks for select values 0 to 3.
- R3: A frame lasts 32 ticks (tick slots 0 to 31). A group is 8 frames (frame indices 0 to 7), that is 256 ticks.
- R4: Within frame f, the output is high in tick slot s exactly when s < C + E(f), where C is the stored coarse value (0 to 31) and E(f) is 0 or 1. High time therefore always starts at slot 0 of the frame.
- R5: E(f) is 1 exactly when the 3-bit reversal of f (bit 0 swapped with bit 2) is below the stored fine value F. F=1 selects frame 0. F=2 selects frames 0 and 4. F=4 selects frames 0, 2, 4 and 6. For F up to 4, no two adjacent frames both carry the extra tick.
- R6: `cfg_coarse` and `cfg_fine` are sampled only on the tick that ends slot 31 of frame 7. A change at any other time has no effect on the output until the next group begins.
- R7: `pwm_out` comes from a register. Counting the first edge with `rst_n` high as edge 1 and writing D for the divisor, group g is visible on the clock cycles after edges 256·D·g+1 through 256·D·(g+1).
- R8: A stored duty of C=0, F=0 keeps the output low for the whole group. C=31 with F=7 keeps the seven selected frames high for all 32 slots.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_div_sel | input | 2 | Tick divider select, divisor 2^(value+1) |
| cfg_coarse | input | 5 | Coarse duty, high ticks per frame |
| cfg_fine | input | 3 | Fine duty, number of frames per group with one extra tick |
| pwm_out | output | 1 | PWM output pin |

## Verification
The bench builds the block with its default widths: a 2-bit divider select, a 5-bit coarse field and a 3-bit fine field. At these widths every divisor from 2 to 16 runs in full, and a complete group of up to 4096 clocks can be compared clock by clock against a model of slot, frame and bit-reversed index. With a 3-bit fine field, every one of the eight frame positions is covered. The extremes C=0/F=0 and C=31/F=7 fit inside a few groups, and so does a duty change made half-way through a group, which exercises the boundary latch.

// File: rtl/frac_pwm_pkg.sv
// frac_pwm_pkg: shared widths and the stored duty word type for the
// dithered frame PWM generator.
// Assumes: frame length is 2^COARSE_W ticks, group length is 2^FINE_W frames.
package frac_pwm_pkg;
    parameter int SEL_W    = 2;   // divider select width
    parameter int COARSE_W = 5;   // coarse duty width, also slot counter width
    parameter int FINE_W   = 3;   // fine duty width, also frame index width

    // Prescaler counter width: largest divisor is 2^(2^SEL_W).
    localparam int CNT_W = 1 << SEL_W;

    typedef struct packed {
        logic [COARSE_W-1:0] coarse;
        logic [FINE_W-1:0]   fine;
    } duty_t;
endpackage

// File: rtl/frac_pwm_prescale.sv
// frac_pwm_prescale: produces a one-clock tick enable every 2^(div_sel+1)
// system clocks.
// Assumes: div_sel may change at any time. A saturating compare guarantees
// that a tick is produced even when the counter is already past the new limit.
module frac_pwm_prescale
    import frac_pwm_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] div_sel,
    output logic             tick
);
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W:0]   cnt_last;

    // Purpose: terminal count for the selected divisor.
    always_comb begin
        cnt_last = ((CNT_W+1)'(2) << div_sel) - (CNT_W+1)'(1);
        tick     = ({1'b0, cnt_q} >= cnt_last);
    end

    // Purpose: free-running divider counter that restarts on every tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/frac_pwm_timebase.sv
// frac_pwm_timebase: tick slot counter within a frame and frame index
// within a group. Flags the tick that closes a group.
// Assumes: tick is a single-clock enable.
module frac_pwm_timebase
    import frac_pwm_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tick,
    output logic [COARSE_W-1:0] slot,
    output logic [FINE_W-1:0]   frame,
    output logic                group_wrap
);
    logic [COARSE_W-1:0] slot_q;
    logic [FINE_W-1:0]   frame_q;

    // Purpose: flag the last tick of the last frame in the group.
    always_comb begin
        group_wrap = tick && (&slot_q) && (&frame_q);
    end

    // Purpose: advance the slot on each tick, and the frame when a slot wraps.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot_q  <= '0;
            frame_q <= '0;
        end else if (tick) begin
            slot_q <= slot_q + 1'b1;
            if (&slot_q) begin
                frame_q <= frame_q + 1'b1;
            end
        end
    end

    assign slot  = slot_q;
    assign frame = frame_q;
endmodule

// File: rtl/frac_pwm_shape.sv
// frac_pwm_shape: holds the duty word for the running group and forms the
// registered output level from slot, frame and the stored duty.
// Assumes: group_wrap marks the one tick on which a new duty may be taken.
module frac_pwm_shape
    import frac_pwm_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                group_wrap,
    input  logic [COARSE_W-1:0] slot,
    input  logic [FINE_W-1:0]   frame,
    input  duty_t               duty_in,
    output duty_t               duty_q,
    output logic                pwm_q
);
    duty_t               shadow_q;
    logic [FINE_W-1:0]   frame_rev;
    logic                extra;
    logic [COARSE_W:0]   limit;
    logic                level;

    // Bit-reversed frame index spreads the extra ticks evenly over the group.
    for (genvar b = 0; b < FINE_W; b++) begin : g_rev
        assign frame_rev[b] = frame[FINE_W-1-b];
    end

    // Purpose: decide whether the current slot is inside the high time.
    always_comb begin
        extra = (frame_rev < shadow_q.fine);
        limit = {1'b0, shadow_q.coarse} + (COARSE_W+1)'(extra);
        level = ({1'b0, slot} < limit);
    end

    // Purpose: take a new duty word only at the group boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shadow_q <= '0;
        end else if (group_wrap) begin
            shadow_q <= duty_in;
        end
    end

    // Purpose: register the output level so the pin is glitch free.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pwm_q <= 1'b0;
        end else begin
            pwm_q <= level;
        end
    end

    assign duty_q = shadow_q;
endmodule

// File: rtl/frac_pwm.sv
// frac_pwm: dithered frame PWM generator, top level.
// Chains the tick prescaler, the slot/frame time base and the output shaper.
// Assumes: a single clock domain and a synchronous active-low reset.
module frac_pwm
    import frac_pwm_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic [SEL_W-1:0]    cfg_div_sel,
    input  logic [COARSE_W-1:0] cfg_coarse,
    input  logic [FINE_W-1:0]   cfg_fine,
    output logic                pwm_out
);
    logic                tick;
    logic [COARSE_W-1:0] slot;
    logic [FINE_W-1:0]   frame;
    logic                group_wrap;
    duty_t               duty_in;
    duty_t               duty_q;

    assign duty_in.coarse = cfg_coarse;
    assign duty_in.fine   = cfg_fine;

    frac_pwm_prescale i_prescale (
        .clk     (clk),
        .rst_n   (rst_n),
        .div_sel (cfg_div_sel),
        .tick    (tick)
    );

    frac_pwm_timebase i_timebase (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick),
        .slot       (slot),
        .frame      (frame),
        .group_wrap (group_wrap)
    );

    frac_pwm_shape i_shape (
        .clk        (clk),
        .rst_n      (rst_n),
        .group_wrap (group_wrap),
        .slot       (slot),
        .frame      (frame),
        .duty_in    (duty_in),
        .duty_q     (duty_q),
        .pwm_q      (pwm_out)
    );
endmodule

// File: rtl/frac_pwm_chk.sv
// frac_pwm_chk: property checker for frac_pwm, attached with bind.
// Assumes: the connected signals are the top-level internal nets of frac_pwm.
module frac_pwm_chk
    import frac_pwm_pkg::*;
(
    input logic                clk,
    input logic                rst_n,
    input logic                tick,
    input logic [COARSE_W-1:0] slot,
    input logic [FINE_W-1:0]   frame,
    input logic                group_wrap,
    input duty_t               duty_q,
    input logic                pwm_out
);
    // R2: the smallest divisor is 2, so two ticks never touch.
    p_tick_gap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);

    // R3: each tick advances the slot by one, wrapping at 32.
    p_slot_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> (slot == $past(slot) + 1'b1));

    // R3: without a tick, slot and frame hold.
    p_slot_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> ($stable(slot) && $stable(frame)));

    // R3: the frame advances when the last slot of a frame ticks.
    p_frame_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && (&slot)) |=> (frame == $past(frame) + 1'b1));

    // R6: the stored duty only moves at the group boundary.
    p_latch_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !group_wrap |=> $stable(duty_q));

    // R4: with a nonzero coarse duty, slot 0 is always high.
    p_first_slot_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ((slot == '0) && (duty_q.coarse != '0)) |=> pwm_out);

    // R8: a zero duty word keeps the output low.
    p_zero_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ((duty_q.coarse == '0) && (duty_q.fine == '0)) |=> !pwm_out);
endmodule

bind frac_pwm frac_pwm_chk i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (tick),
    .slot       (slot),
    .frame      (frame),
    .group_wrap (group_wrap),
    .duty_q     (duty_q),
    .pwm_out    (pwm_out)
);

// File: tb/test_frac_pwm.sv
module test_frac_pwm;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] cfg_div_sel = 2'd0;
    logic [4:0] cfg_coarse = 5'd0;
    logic [2:0] cfg_fine = 3'd0;
    logic       pwm_out;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    frac_pwm i_frac_pwm (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_div_sel (cfg_div_sel),
        .cfg_coarse  (cfg_coarse),
        .cfg_fine    (cfg_fine),
        .pwm_out     (pwm_out)
    );

    function automatic int rev3(int f);
        return ((f & 1) << 2) | (f & 2) | ((f >> 2) & 1);
    endfunction

    // Expected level on the cycle after edge j (j counted from 1 after reset)
    // inside a group of the given duty (R3, R4, R5, R7).
    function automatic logic exp_level(int j, int dv, int c, int f);
        int p  = (j - 1) % (256 * dv);
        int fr = p / (32 * dv);
        int s  = (p % (32 * dv)) / dv;
        int ex = (rev3(fr) < f) ? 1 : 0;
        return (s < c + ex);
    endfunction

    task automatic check(bit ok, string tag, int act, int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    // Reset with duty A; group 0 low, group 1 shows A, B written mid-group 1,
    // group 2 shows B.
    task automatic run_case(int sel, int ca, int fa, int cb, int fb, string tag);
        int dv = 2 << sel;
        int g_len = 256 * dv;
        int f_len = 32 * dv;
        int miss = 0;
        int first_act = 0;
        int first_exp = 0;
        int highs = 0;
        @(negedge clk);
        rst_n = 1'b0;
        cfg_div_sel = 2'(sel);
        cfg_coarse  = 5'(ca);
        cfg_fine    = 3'(fa);
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(pwm_out == 1'b0, "R1 reset level", int'(pwm_out), 0);
        rst_n = 1'b1;
        for (int j = 1; j <= 3 * g_len; j++) begin
            int g = (j - 1) / g_len;
            logic e;
            @(posedge clk);
            @(negedge clk);
            if (g == 0)      e = 1'b0;
            else if (g == 1) e = exp_level(j, dv, ca, fa);
            else             e = exp_level(j, dv, cb, fb);
            if (pwm_out !== e) begin
                if (miss == 0) begin
                    first_act = int'(pwm_out);
                    first_exp = int'(e);
                end
                miss++;
            end
            if (pwm_out === 1'b1) highs++;
            if (j % f_len == 0) begin
                if (g == 0)
                    check(miss == 0, {"R1 first group low ", tag}, first_act, first_exp);
                else if (g == 1)
                    check(miss == 0, {"R4 R5 R7 frame shape ", tag}, first_act, first_exp);
                else
                    check(miss == 0, {"R6 new duty from next group ", tag}, first_act, first_exp);
                miss = 0;
            end
            if (j % g_len == 0) begin
                int ce = (g == 0) ? 0 : (g == 1) ? ca : cb;
                int fe = (g == 0) ? 0 : (g == 1) ? fa : fb;
                check(highs == dv * (8 * ce + fe),
                      {"R2 R3 high clocks per group ", tag}, highs, dv * (8 * ce + fe));
                highs = 0;
            end
            if (j == g_len + g_len / 2) begin
                cfg_coarse = 5'(cb);
                cfg_fine   = 3'(fb);
            end
        end
    endtask

    initial begin
        int s;
        s = $urandom(32'd20240611);
        run_case(0, 0, 0, 31, 7, "R8 zero then full");
        run_case(3, 16, 3, 0, 0, "R8 half then zero");
        run_case(1, 1, 1, 30, 4, "R5 sparse spread");
        run_case(2, 31, 0, 5, 2, "R4 coarse top");
        for (int k = 0; k < 5; k++) begin
            int sel = int'($urandom % 4);
            if (sel == 3) sel = 2;
            run_case(sel, int'($urandom % 32), int'($urandom % 8),
                     int'($urandom % 32), int'($urandom % 8), "random");
        end
        if (!done) begin
            done = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog R3 actual=%0d expected=%0d", 1, 0);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule